// File: doc/BRIEF.md
# DSI Video-Mode Line Timing Generator

This block produces the horizontal and vertical framing for a video-mode display-serial transmitter and runs entirely in the lane byte-clock domain. Horizontal timing uses mixed units. Sync width, back porch and total line length are programmed as byte-clock cycle counts. The active region lasts one cycle per displayed pixel. The front porch has no setting of its own: it is whatever is left of the line after the other three regions. Vertical timing is programmed in whole lines, and the frame runs through sync, back porch, active and front porch in that order.

A packet builder downstream uses the per-cycle region codes, the data-enable, the line and frame strobes and the polarity-adjusted sync outputs to decide what to send. The programmed values are copied into a shadow set only at a frame boundary, so a host can rewrite them at any time without tearing the current frame. A line whose sync and back porch leave no room, or a frame of zero lines, raises an error flag. Counting then stops until a usable setting is presented.

Top module: `dsi_line_timer`

## Requirements
- R1: Each line lasts exactly `cfg_line_len_i` cycles. Its horizontal region code (0 sync, 1 back porch, 2 active, 3 front porch) is 0 for `cfg_hsync_len_i` cycles, then 1 for `cfg_hback_len_i` cycles, then 2 for min(`cfg_pixels_i`, line − sync − back porch) cycles, then 3 for the rest of the line.
- R2: The vertical region code uses the same encoding and advances once per line. It runs through sync lines, back-porch lines, active lines and front-porch lines, and then the frame repeats.
- R3: A programmed vertical sync count above 15 lines is treated as 15.
- R4: `cfg_pol_i` bit 2 set makes `hsync_o` active low and bit 1 set makes `vsync_o` active low. Bit 0 is ignored. While the timer is stopped, both sync outputs sit at their inactive level.
- R5: `cfg_flags_i` is {sync-pulse, burst, video} in bits 2..0. The value 3'b101 selects non-burst with sync pulses (`vmode_o` = 0), 3'b001 selects non-burst with sync events (`vmode_o` = 1), and every other value selects burst (`vmode_o` = 2).
- R6: In sync-event mode, each sync output is asserted for only the single cycle at which its sync region starts, and only if that sync width is non-zero. In the other two modes, it is asserted for the whole sync region.
- R7: `line_start_o` pulses on the first cycle of every line, and `frame_start_o` pulses on the first cycle of line 0 only.
- R8: When sync plus back porch is at least the line length, or the four vertical counts sum to zero, `cfg_err_o` is set and the timer holds: region codes read 0, and `de_o` and both strobes stay low. Counting resumes with a new frame one cycle after a valid setting is presented.
- R9: Configuration inputs are sampled only on the last cycle of a frame, or on any cycle while stopped. A mid-frame change has no effect on the outputs until the next frame start.
- R10: During reset, all region codes, strobes, `de_o`, `vmode_o` and `cfg_err_o` are 0, and the sync outputs are low.
- R11: `de_o` is high exactly when both the horizontal and the vertical region codes are 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hsync_len_i | input | H_W | Horizontal sync width, byte-clock cycles |
| cfg_hback_len_i | input | H_W | Horizontal back porch, byte-clock cycles |
| cfg_line_len_i | input | H_W | Total line length, byte-clock cycles |
| cfg_pixels_i | input | P_W | Displayed pixels per line |
| cfg_vsync_lines_i | input | V_W | Vertical sync lines (saturates at 15) |
| cfg_vback_lines_i | input | V_W | Vertical back-porch lines |
| cfg_vact_lines_i | input | V_W | Vertical active lines |
| cfg_vfront_lines_i | input | V_W | Vertical front-porch lines |
| cfg_pol_i | input | 3 | Polarity: bit 2 hsync low, bit 1 vsync low |
| cfg_flags_i | input | 3 | Video mode flags {pulse, burst, video} |
| h_region_o | output | 2 | Horizontal region code |
| v_region_o | output | 2 | Vertical region code |
| de_o | output | 1 | Active pixel cycle |
| line_start_o | output | 1 | First cycle of a line |
| frame_start_o | output | 1 | First cycle of a frame |
| hsync_o | output | 1 | Polarity-adjusted horizontal sync |
| vsync_o | output | 1 | Polarity-adjusted vertical sync |
| vmode_o | output | 2 | Decoded video mode in force |
| cfg_err_o | output | 1 | Configuration error, timer held |

## Verification
The bench builds the timer with H_W=8, V_W=6 and P_W=6. This keeps each frame to a few hundred cycles, so many complete frames, mid-frame reprogramming and several mode changes fit in a short run. The 6-bit vertical fields can express a sync count of 20, which exercises the saturation at 15. The 6-bit pixel field can exceed the space left in an 18-cycle line, which exercises truncation of the active region down to a zero-length front porch. Both error conditions and recovery from them are also driven from these narrow fields.

// File: rtl/dlt_pkg.sv
package dlt_pkg;

    // Region encoding shared by the horizontal and vertical axes
    typedef enum logic [1:0] {
        REG_SYNC  = 2'd0,
        REG_BACK  = 2'd1,
        REG_ACT   = 2'd2,
        REG_FRONT = 2'd3
    } region_e;

    // Video mode in force for the current frame
    typedef enum logic [1:0] {
        VM_PULSE = 2'd0,
        VM_EVENT = 2'd1,
        VM_BURST = 2'd2
    } vmode_e;

endpackage

// File: rtl/dlt_mode_decode.sv
module dlt_mode_decode
    import dlt_pkg::*;
(
    input  logic [2:0] flags_i,
    output vmode_e     mode_o
);

    // R5: only the two exact non-burst patterns escape the burst default
    always_comb begin
        case (flags_i)
            3'b101:  mode_o = VM_PULSE;
            3'b001:  mode_o = VM_EVENT;
            default: mode_o = VM_BURST;
        endcase
    end

endmodule

// File: rtl/dlt_region_cmp.sv
module dlt_region_cmp
    import dlt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] pos_i,
    input  logic [W-1:0] sync_end_i,
    input  logic [W-1:0] back_end_i,
    input  logic [W-1:0] act_end_i,
    output region_e      region_o
);

    // Cumulative end points: a zero-length region is skipped naturally
    always_comb begin
        if (pos_i < sync_end_i)
            region_o = REG_SYNC;
        else if (pos_i < back_end_i)
            region_o = REG_BACK;
        else if (pos_i < act_end_i)
            region_o = REG_ACT;
        else
            region_o = REG_FRONT;
    end

endmodule

// File: rtl/dsi_line_timer.sv
module dsi_line_timer
    import dlt_pkg::*;
#(
    parameter int H_W = 12,
    parameter int V_W = 11,
    parameter int P_W = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [H_W-1:0] cfg_hsync_len_i,
    input  logic [H_W-1:0] cfg_hback_len_i,
    input  logic [H_W-1:0] cfg_line_len_i,
    input  logic [P_W-1:0] cfg_pixels_i,
    input  logic [V_W-1:0] cfg_vsync_lines_i,
    input  logic [V_W-1:0] cfg_vback_lines_i,
    input  logic [V_W-1:0] cfg_vact_lines_i,
    input  logic [V_W-1:0] cfg_vfront_lines_i,
    input  logic [2:0]     cfg_pol_i,
    input  logic [2:0]     cfg_flags_i,
    output logic [1:0]     h_region_o,
    output logic [1:0]     v_region_o,
    output logic           de_o,
    output logic           line_start_o,
    output logic           frame_start_o,
    output logic           hsync_o,
    output logic           vsync_o,
    output logic [1:0]     vmode_o,
    output logic           cfg_err_o
);

    // Horizontal compare width covers both sync+porch sums and the pixel count
    localparam int CW   = (P_W > H_W + 1) ? P_W : H_W + 1;
    // Frame line count: sum of four V_W-wide fields
    localparam int VT_W = V_W + 2;
    localparam logic [3:0] VSA_MAX = 4'd15;

    typedef struct packed {
        logic [H_W-1:0] hsa;
        logic [H_W-1:0] hbp;
        logic [H_W-1:0] line;
        logic [P_W-1:0] pix;
        logic [3:0]     vsa;
        logic [V_W-1:0] vbp;
        logic [V_W-1:0] vact;
        logic [V_W-1:0] vfp;
        logic           hs_low;
        logic           vs_low;
        vmode_e         mode;
    } shadow_t;

    typedef struct packed {
        shadow_t         sh;
        logic            run;
        logic            err;
        logic [H_W-1:0]  h;
        logic [VT_W-1:0] v;
    } state_t;

    state_t  st_d, st_q;
    shadow_t in_sh;
    vmode_e  in_mode;
    logic    in_err;
    logic [CW-1:0]   in_hb;
    logic [VT_W-1:0] in_vtot;

    // ---------------- incoming configuration ----------------
    dlt_mode_decode u_mode (
        .flags_i (cfg_flags_i),
        .mode_o  (in_mode)
    );

    always_comb begin
        in_sh.hsa    = cfg_hsync_len_i;
        in_sh.hbp    = cfg_hback_len_i;
        in_sh.line   = cfg_line_len_i;
        in_sh.pix    = cfg_pixels_i;
        // R3: vertical sync saturates at 15 lines
        in_sh.vsa    = (cfg_vsync_lines_i > V_W'(VSA_MAX)) ? VSA_MAX
                                                           : cfg_vsync_lines_i[3:0];
        in_sh.vbp    = cfg_vback_lines_i;
        in_sh.vact   = cfg_vact_lines_i;
        in_sh.vfp    = cfg_vfront_lines_i;
        in_sh.hs_low = cfg_pol_i[2];
        in_sh.vs_low = cfg_pol_i[1];
        in_sh.mode   = in_mode;
        in_hb   = CW'(cfg_hsync_len_i) + CW'(cfg_hback_len_i);
        in_vtot = VT_W'(in_sh.vsa) + VT_W'(cfg_vback_lines_i)
                + VT_W'(cfg_vact_lines_i) + VT_W'(cfg_vfront_lines_i);
        // R8: no room after sync and back porch, or an empty frame
        in_err  = (in_hb >= CW'(cfg_line_len_i)) || (in_vtot == '0);
    end

    // ---------------- derived boundaries of the shadow set ----------------
    logic [CW-1:0]   hs_end, hb_end, ha_end, line_x, avail, pix_x, act_len, h_x;
    logic [VT_W-1:0] vs_end, vb_end, va_end, vtot;
    region_e         hreg, vreg;
    logic            line_last, frame_last;

    always_comb begin
        line_x  = CW'(st_q.sh.line);
        hs_end  = CW'(st_q.sh.hsa);
        hb_end  = hs_end + CW'(st_q.sh.hbp);
        avail   = line_x - hb_end;
        pix_x   = CW'(st_q.sh.pix);
        act_len = (pix_x < avail) ? pix_x : avail;
        ha_end  = hb_end + act_len;
        h_x     = CW'(st_q.h);
        vs_end  = VT_W'(st_q.sh.vsa);
        vb_end  = vs_end + VT_W'(st_q.sh.vbp);
        va_end  = vb_end + VT_W'(st_q.sh.vact);
        vtot    = va_end + VT_W'(st_q.sh.vfp);
        line_last  = (st_q.h == st_q.sh.line - 1'b1);
        frame_last = line_last && (st_q.v == vtot - 1'b1);
    end

    dlt_region_cmp #(.W(CW)) u_hreg (
        .pos_i      (h_x),
        .sync_end_i (hs_end),
        .back_end_i (hb_end),
        .act_end_i  (ha_end),
        .region_o   (hreg)
    );

    dlt_region_cmp #(.W(VT_W)) u_vreg (
        .pos_i      (st_q.v),
        .sync_end_i (vs_end),
        .back_end_i (vb_end),
        .act_end_i  (va_end),
        .region_o   (vreg)
    );

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        if (!st_q.run || frame_last) begin
            // R9: shadow reloads only at a frame boundary or while held
            st_d.sh  = in_sh;
            st_d.run = !in_err;
            st_d.err = in_err;
            st_d.h   = '0;
            st_d.v   = '0;
        end else if (line_last) begin
            st_d.h = '0;
            st_d.v = st_q.v + 1'b1;
        end else begin
            st_d.h = st_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // ---------------- outputs ----------------
    logic hs_act, vs_act, at_line0;

    always_comb begin
        at_line0 = (st_q.h == '0);
        hs_act   = 1'b0;
        vs_act   = 1'b0;
        h_region_o    = REG_SYNC;
        v_region_o    = REG_SYNC;
        de_o          = 1'b0;
        line_start_o  = 1'b0;
        frame_start_o = 1'b0;
        if (st_q.run) begin
            h_region_o    = hreg;
            v_region_o    = vreg;
            de_o          = (hreg == REG_ACT) && (vreg == REG_ACT);
            line_start_o  = at_line0;
            frame_start_o = at_line0 && (st_q.v == '0);
            if (st_q.sh.mode == VM_EVENT) begin
                hs_act = at_line0 && (st_q.sh.hsa != '0);
                vs_act = at_line0 && (st_q.v == '0) && (st_q.sh.vsa != '0);
            end else begin
                hs_act = (hreg == REG_SYNC);
                vs_act = (vreg == REG_SYNC);
            end
        end
        hsync_o   = hs_act ^ st_q.sh.hs_low;
        vsync_o   = vs_act ^ st_q.sh.vs_low;
        vmode_o   = st_q.sh.mode;
        cfg_err_o = st_q.err;
    end

endmodule

// File: rtl/dsi_line_timer_chk.sv
module dsi_line_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] h_region_o,
    input logic [1:0] v_region_o,
    input logic       de_o,
    input logic       line_start_o,
    input logic       frame_start_o,
    input logic [1:0] vmode_o,
    input logic       cfg_err_o,
    input logic       hs_act
);

    // R1: within a line the horizontal region never steps backwards
    a_r1_hreg_order: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start_o && !cfg_err_o) |-> (h_region_o >= $past(h_region_o)));

    // R2: within a frame the vertical region never steps backwards
    a_r2_vreg_order: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start_o && !cfg_err_o) |-> (v_region_o >= $past(v_region_o)));

    // R7: a frame start is always also a line start
    a_r7_frame_is_line: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> line_start_o);

    // R8: an error holds the timer quiet
    a_r8_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (!de_o && !line_start_o && !frame_start_o));

    // R6: in sync-event mode the horizontal sync lasts one cycle only
    a_r6_event_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (vmode_o == 2'd1 && hs_act) |=> !hs_act);

endmodule

bind dsi_line_timer dsi_line_timer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .h_region_o    (h_region_o),
    .v_region_o    (v_region_o),
    .de_o          (de_o),
    .line_start_o  (line_start_o),
    .frame_start_o (frame_start_o),
    .vmode_o       (vmode_o),
    .cfg_err_o     (cfg_err_o),
    .hs_act        (hs_act)
);

// File: tb/dsi_line_timer_bench.sv
`timescale 1ns/1ps
module dsi_line_timer_bench;

    localparam int HWB = 8;
    localparam int VWB = 6;
    localparam int PWB = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [HWB-1:0] hsa_i = '0, hbp_i = '0, line_i = '0;
    logic [PWB-1:0] pix_i = '0;
    logic [VWB-1:0] vs_i = '0, vb_i = '0, va_i = '0, vf_i = '0;
    logic [2:0] pol_i = '0, flags_i = '0;

    logic [1:0] h_region, v_region, vmode;
    logic de, lstart, fstart, hsync, vsync, err;

    always #2 clk = ~clk;   // 250 MHz

    dsi_line_timer #(.H_W(HWB), .V_W(VWB), .P_W(PWB)) u_dsi_line_timer (
        .clk (clk), .rst_n (rst_n),
        .cfg_hsync_len_i (hsa_i), .cfg_hback_len_i (hbp_i), .cfg_line_len_i (line_i),
        .cfg_pixels_i (pix_i),
        .cfg_vsync_lines_i (vs_i), .cfg_vback_lines_i (vb_i),
        .cfg_vact_lines_i (va_i), .cfg_vfront_lines_i (vf_i),
        .cfg_pol_i (pol_i), .cfg_flags_i (flags_i),
        .h_region_o (h_region), .v_region_o (v_region), .de_o (de),
        .line_start_o (lstart), .frame_start_o (fstart),
        .hsync_o (hsync), .vsync_o (vsync), .vmode_o (vmode), .cfg_err_o (err)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    string scen = "R10 reset";

    // ---------------- behavioural reference ----------------
    int m_run = 0, m_err = 0, mh = 0, mv = 0;
    int s_hsa = 0, s_hbp = 0, s_line = 0, s_pix = 0;
    int s_vsa = 0, s_vbp = 0, s_vact = 0, s_vfp = 0;
    int s_hl = 0, s_vl = 0, s_mode = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_err = 0; mh = 0; mv = 0;
            s_hsa = 0; s_hbp = 0; s_line = 0; s_pix = 0;
            s_vsa = 0; s_vbp = 0; s_vact = 0; s_vfp = 0;
            s_hl = 0; s_vl = 0; s_mode = 0;
        end else begin
            int frame_lines;
            bit at_end;
            frame_lines = s_vsa + s_vbp + s_vact + s_vfp;
            at_end = (mh == s_line - 1) && (mv == frame_lines - 1);
            if (m_run == 0 || at_end) begin
                int vclamp, bad;
                vclamp = (int'(vs_i) > 15) ? 15 : int'(vs_i);
                bad = ((int'(hsa_i) + int'(hbp_i)) >= int'(line_i)) ||
                      ((vclamp + int'(vb_i) + int'(va_i) + int'(vf_i)) == 0);
                s_hsa = hsa_i; s_hbp = hbp_i; s_line = line_i; s_pix = pix_i;
                s_vsa = vclamp; s_vbp = vb_i; s_vact = va_i; s_vfp = vf_i;
                s_hl = pol_i[2]; s_vl = pol_i[1];
                s_mode = (flags_i == 3'b101) ? 0 : (flags_i == 3'b001) ? 1 : 2;
                m_run = !bad; m_err = bad; mh = 0; mv = 0;
            end else if (mh == s_line - 1) begin
                mh = 0; mv = mv + 1;
            end else begin
                mh = mh + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s: got %0d expected %0d", req, scen, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (!done) begin
            int eh, ev, ede, els, efs, ehs, evs;
            eh = 0; ev = 0; ede = 0; els = 0; efs = 0; ehs = 0; evs = 0;
            if (m_run != 0) begin
                int act_len;
                act_len = s_line - s_hsa - s_hbp;
                if (s_pix < act_len) act_len = s_pix;
                eh = (mh < s_hsa) ? 0 : (mh < s_hsa + s_hbp) ? 1 :
                     (mh < s_hsa + s_hbp + act_len) ? 2 : 3;
                ev = (mv < s_vsa) ? 0 : (mv < s_vsa + s_vbp) ? 1 :
                     (mv < s_vsa + s_vbp + s_vact) ? 2 : 3;
                ede = (eh == 2 && ev == 2);
                els = (mh == 0);
                efs = (mh == 0 && mv == 0);
                if (s_mode == 1) begin
                    ehs = (mh == 0 && s_hsa > 0);
                    evs = (efs && s_vsa > 0);
                end else begin
                    ehs = (eh == 0);
                    evs = (ev == 0);
                end
            end
            chk("R1",  "h_region",    h_region, eh);
            chk("R2",  "v_region",    v_region, ev);
            chk("R11", "de",          de, ede);
            chk("R7",  "line_start",  lstart, els);
            chk("R7",  "frame_start", fstart, efs);
            chk("R4",  "hsync",       hsync, ehs ^ s_hl);
            chk("R4",  "vsync",       vsync, evs ^ s_vl);
            chk("R5",  "vmode",       vmode, s_mode);
            chk("R8",  "cfg_err",     err, m_err);
        end
    end

    task automatic set_h(input int hs, input int hb, input int ln, input int px);
        hsa_i = HWB'(hs); hbp_i = HWB'(hb); line_i = HWB'(ln); pix_i = PWB'(px);
    endtask

    task automatic set_v(input int s, input int b, input int a, input int f);
        vs_i = VWB'(s); vb_i = VWB'(b); va_i = VWB'(a); vf_i = VWB'(f);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog [%s]: got 0 expected 1", scen);
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: reset values while held
        wait_cycles(5);
        scen = "R1 R2 pulse mode";
        set_h(3, 4, 20, 8); set_v(2, 1, 3, 2);
        pol_i = 3'b000; flags_i = 3'b101;
        rst_n = 1'b1;
        wait_cycles(250);
        // R9: mid-frame rewrite waits for the frame boundary; R6 events; R3 clamp
        scen = "R9 R6 R3 events, clamp, low pols";
        set_h(2, 3, 16, 6); set_v(20, 1, 2, 1);
        pol_i = 3'b110; flags_i = 3'b001;
        wait_cycles(700);
        // Burst with pixels exceeding the room left (front porch zero)
        scen = "R5 R1 burst, truncated active";
        set_h(2, 2, 18, 30); set_v(1, 2, 3, 0);
        pol_i = 3'b101; flags_i = 3'b011;
        wait_cycles(400);
        // Horizontal error: sync + porch fills the line
        scen = "R8 horizontal error";
        set_h(10, 10, 20, 4);
        wait_cycles(300);
        // Vertical error: empty frame
        scen = "R8 empty frame";
        set_h(1, 1, 12, 4); set_v(0, 0, 0, 0);
        wait_cycles(60);
        // Recovery, all three flags set decodes to burst
        scen = "R8 recovery burst default";
        set_v(1, 1, 2, 1); flags_i = 3'b111; pol_i = 3'b010;
        wait_cycles(200);
        // Reset mid-run
        scen = "R10 reset mid-run";
        rst_n = 1'b0;
        wait_cycles(4);
        scen = "R7 after reset";
        set_h(1, 0, 5, 2); set_v(1, 0, 2, 1); flags_i = 3'b101; pol_i = 3'b000;
        rst_n = 1'b1;
        wait_cycles(120);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule